// File: doc/BRIEF.md
# Pulse-Counted Set-Point Jog Controller

This block produces the 5-bit set-point code that a downstream switching-regulator controller follows. With jog mode off, a control pin simply chooses between a programmed normal code and an alternate code. With jog mode on, the same pin becomes a command strobe. While the pin is high, the block counts falling edges of a separate serial clock. When the pin falls, it turns the count into a command that changes a working copy of the normal code.

The commands are as follows. No edge leaves the set point alone. One edge lowers it by one code step of 25 mV. Two edges raise it by one step. Three or more edges are a panic request: the working code goes straight back to the programmed normal code. Upper and lower stop inputs bound single steps. The programmed normal code is only read and never written.

Both asynchronous inputs pass through a two-flop synchronizer into the system clock domain. The count starts again from zero on every rising edge of the control pin.

Top module: `sp_jog_ctrl`

## Requirements
- R1: While reset is held and after it is released, with jog mode off and the control pin low, `sp_out` equals `nrm_code`.
- R2: With jog mode off, `sp_out` shows `alt_code` while the synchronized control pin is high and `nrm_code` while it is low.
- R3: When jog mode is turned on, `sp_out` starts at `nrm_code`.
- R4: A high pulse with no serial-clock falling edge leaves the working code unchanged.
- R5: A high pulse with exactly one serial-clock falling edge lowers the working code by 1, which is one 25 mV step (code 11010 = 1.250 V becomes 11001 = 1.225 V).
- R6: A high pulse with exactly two falling edges raises the working code by 1 (11010 becomes 11011 = 1.275 V).
- R7: A high pulse with three or more falling edges sets the working code to `nrm_code`. The edge count saturates at 3.
- R8: An increase is ignored when the working code is already at or above `stop_hi`.
- R9: A decrease is ignored when the working code is already at or below `stop_lo`.
- R10: While jog mode is on, any change of `nrm_code` reloads the working code from it.
- R11: While jog mode is on, `sp_out` shows only the working code. The control pin never selects `alt_code`, and the working code does not change until the pulse ends.
- R12: The edge count is cleared at the start of each high pulse, so edges from earlier pulses never add to the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| jog_en | input | 1 | Jog mode enable |
| ctl_pin | input | 1 | Asynchronous control pin: set-point select, or command strobe in jog mode |
| ser_clk | input | 1 | Asynchronous serial clock whose falling edges are counted |
| nrm_code | input | 5 | Programmed normal set-point code |
| alt_code | input | 5 | Programmed alternate set-point code |
| stop_hi | input | 5 | Upper stop for single steps |
| stop_lo | input | 5 | Lower stop for single steps |
| sp_out | output | 5 | Set-point code delivered to the regulator controller |

## Verification
The embedded assertions check every cycle that a decoded command moves the working code by exactly one code, or to the normal code on panic, and that it stays put at a stop. They also check that the code is otherwise frozen while jog mode is on and that the edge count is cleared after each rising edge of the pin. The bench scenarios show what the assertions cannot: that real pulse trains on the two asynchronous pins decode to the right command after synchronization, that four edges still count as panic, and that counts do not leak from one pulse into the next. They also show the pin-select behaviour with jog mode off and the reload on enable or on a change of the normal code.

// File: rtl/jog_pkg.sv
package jog_pkg;

  typedef enum logic [1:0] {
    JOG_NONE  = 2'd0,
    JOG_DOWN  = 2'd1,
    JOG_UP    = 2'd2,
    JOG_PANIC = 2'd3
  } jog_cmd_e;

  localparam int unsigned JOG_PANIC_COUNT = 3;

  // Map a saturated edge count onto a command.
  function automatic jog_cmd_e jog_decode(input int unsigned n);
    jog_cmd_e c;
    case (n)
      0:       c = JOG_NONE;
      1:       c = JOG_DOWN;
      2:       c = JOG_UP;
      default: c = JOG_PANIC;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/jog_sync.sv
module jog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);

  localparam int LAST = STAGES;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], async_in};
  end

  assign level = chain[LAST-1];
  assign rise  =  chain[LAST-1] & ~chain[LAST];
  assign fall  = ~chain[LAST-1] &  chain[LAST];

endmodule

// File: rtl/jog_edge_cnt.sv
module jog_edge_cnt
  import jog_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_level,
  input  logic     pin_rise,
  input  logic     pin_fall,
  input  logic     sclk_fall,
  output logic     cmd_vld,
  output jog_cmd_e cmd
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(JOG_PANIC_COUNT);

  logic [CNT_W-1:0] cnt;
  logic             cnt_inc;

  assign cnt_inc = pin_level & sclk_fall & (cnt != SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (pin_rise) cnt <= '0;
    else if (cnt_inc)  cnt <= cnt + 1'b1;
  end

  assign cmd_vld = pin_fall;
  assign cmd     = jog_decode(int'(cnt));

  // R12: the count restarts at each new pulse.
  assert_cnt_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> (cnt == '0));

  // R7: the count never passes the panic threshold.
  assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == SAT && !pin_rise) |=> (cnt == SAT));

endmodule

// File: rtl/jog_setpoint.sv
module jog_setpoint
  import jog_pkg::*;
#(
  parameter int SP_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            jog_en,
  input  logic            cmd_vld,
  input  jog_cmd_e        cmd,
  input  logic [SP_W-1:0] nrm_code,
  input  logic [SP_W-1:0] stop_hi,
  input  logic [SP_W-1:0] stop_lo,
  output logic [SP_W-1:0] work
);

  logic [SP_W-1:0] nrm_q;
  logic            nrm_chg;
  logic            reload;

  // Next working code for a decoded command, with the stops applied.
  function automatic logic [SP_W-1:0] next_code(
    input logic [SP_W-1:0] cur,
    input jog_cmd_e        c,
    input logic [SP_W-1:0] nrm,
    input logic [SP_W-1:0] hi,
    input logic [SP_W-1:0] lo
  );
    logic [SP_W-1:0] r;
    r = cur;
    case (c)
      JOG_DOWN:  if (cur > lo) r = cur - 1'b1;
      JOG_UP:    if (cur < hi) r = cur + 1'b1;
      JOG_PANIC: r = nrm;
      default:   r = cur;
    endcase
    return r;
  endfunction

  assign nrm_chg = (nrm_code != nrm_q);
  assign reload  = !jog_en || nrm_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrm_q <= '0;
      work  <= '0;
    end else begin
      nrm_q <= nrm_code;
      if (reload)       work <= nrm_code;
      else if (cmd_vld) work <= next_code(work, cmd, nrm_code, stop_hi, stop_lo);
    end
  end

  assert_up_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && cmd_vld && cmd == JOG_UP && work >= stop_hi) |=> $stable(work));

  assert_down_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && cmd_vld && cmd == JOG_DOWN && work <= stop_lo) |=> $stable(work));

  assert_down_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && cmd_vld && cmd == JOG_DOWN && work > stop_lo)
      |=> (work == $past(work) - 1'b1));

  assert_up_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && cmd_vld && cmd == JOG_UP && work < stop_hi)
      |=> (work == $past(work) + 1'b1));

  assert_panic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (jog_en && cmd_vld && cmd == JOG_PANIC) |=> (work == $past(nrm_code)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && (!cmd_vld || cmd == JOG_NONE)) |=> $stable(work));

  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (jog_en && nrm_chg) |=> (work == $past(nrm_code)));

endmodule

// File: rtl/sp_jog_ctrl.sv
module sp_jog_ctrl
  import jog_pkg::*;
#(
  parameter int SP_W        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            jog_en,
  input  logic            ctl_pin,
  input  logic            ser_clk,
  input  logic [SP_W-1:0] nrm_code,
  input  logic [SP_W-1:0] alt_code,
  input  logic [SP_W-1:0] stop_hi,
  input  logic [SP_W-1:0] stop_lo,
  output logic [SP_W-1:0] sp_out
);

  localparam int CNT_W = $clog2(JOG_PANIC_COUNT + 1);

  logic            pin_level, pin_rise, pin_fall;
  logic            sclk_level, sclk_rise, sclk_fall;
  logic            cmd_vld;
  jog_cmd_e        cmd;
  logic [SP_W-1:0] work;

  jog_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ctl_pin),
    .level(pin_level), .rise(pin_rise), .fall(pin_fall)
  );

  jog_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ser_clk),
    .level(sclk_level), .rise(sclk_rise), .fall(sclk_fall)
  );

  jog_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .pin_level(pin_level), .pin_rise(pin_rise), .pin_fall(pin_fall),
    .sclk_fall(sclk_fall), .cmd_vld(cmd_vld), .cmd(cmd)
  );

  jog_setpoint #(.SP_W(SP_W)) u_sp (
    .clk(clk), .rst_n(rst_n), .jog_en(jog_en),
    .cmd_vld(cmd_vld), .cmd(cmd), .nrm_code(nrm_code),
    .stop_hi(stop_hi), .stop_lo(stop_lo), .work(work)
  );

  assign sp_out = jog_en ? work : (pin_level ? alt_code : nrm_code);

  // R11: while the pin is high in jog mode, the output does not move.
  assert_pulse_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (jog_en && $past(jog_en) && pin_level && $stable(nrm_code)) |-> $stable(sp_out));

  // sclk_level and sclk_rise are not needed by the decode.
  logic unused_sclk;
  assign unused_sclk = sclk_level ^ sclk_rise;

endmodule

// File: tb/tb_sp_jog_ctrl.sv
module tb_sp_jog_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       jog_en = 1'b0;
  logic       ctl_pin = 1'b0;
  logic       ser_clk = 1'b0;
  logic [4:0] nrm_code = 5'b11010;
  logic [4:0] alt_code = 5'd20;
  logic [4:0] stop_hi = 5'd31;
  logic [4:0] stop_lo = 5'd0;
  logic [4:0] sp_out;

  always #2 clk = ~clk;

  sp_jog_ctrl dut (
    .clk(clk), .rst_n(rst_n), .jog_en(jog_en), .ctl_pin(ctl_pin),
    .ser_clk(ser_clk), .nrm_code(nrm_code), .alt_code(alt_code),
    .stop_hi(stop_hi), .stop_lo(stop_lo), .sp_out(sp_out)
  );

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } item_t;

  item_t      sb[$];
  int         n_chk = 0;
  int         n_fail = 0;
  logic [4:0] model;
  bit         done = 1'b0;

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (sp_out !== it.exp) begin
        n_fail++;
        $display("FAIL %s: sp_out=%0d expected=%0d", it.tag, sp_out, it.exp);
      end
    end
  end

  task automatic expect_out(input logic [4:0] e, input string tag);
    @(posedge clk); #1;
    sb.push_back('{exp: e, tag: tag});
    @(negedge clk); @(negedge clk);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one command pulse carrying n serial-clock falling edges.
  task automatic pulse(input int n, input bit mid_check);
    @(negedge clk); ctl_pin = 1'b1;
    wait_clk(4);
    for (int i = 0; i < n; i++) begin
      ser_clk = 1'b1; wait_clk(3);
      ser_clk = 1'b0; wait_clk(3);
    end
    if (mid_check) expect_out(model, "R11 output frozen during pulse, alt ignored");
    ctl_pin = 1'b0;
    wait_clk(8);
  endtask

  // Independent model of a decoded command.
  task automatic apply(input int n);
    if (n == 1) begin
      if (model > stop_lo) model = model - 5'd1;
    end else if (n == 2) begin
      if (model < stop_hi) model = model + 5'd1;
    end else if (n >= 3) begin
      model = nrm_code;
    end
  endtask

  task automatic jog(input int n, input string tag);
    pulse(n, 1'b0);
    apply(n);
    expect_out(model, tag);
  endtask

  initial begin
    wait_clk(3);
    expect_out(5'b11010, "R1 reset output");
    rst_n = 1'b1;
    wait_clk(2);
    expect_out(5'b11010, "R1 after reset");

    ctl_pin = 1'b1; wait_clk(4);
    expect_out(5'd20, "R2 pin high selects alternate");
    ctl_pin = 1'b0; wait_clk(4);
    expect_out(5'b11010, "R2 pin low selects normal");

    jog_en = 1'b1; wait_clk(2);
    model = nrm_code;
    expect_out(5'b11010, "R3 start at normal");

    jog(1, "R5 one edge steps down");
    expect_out(5'b11001, "R5 code 25 is 1.225 V");
    jog(2, "R6 two edges step up");
    jog(2, "R6 second step up");
    expect_out(5'b11011, "R6 code 27 is 1.275 V");
    pulse(0, 1'b1); apply(0);
    expect_out(model, "R4 zero edges hold");
    pulse(2, 1'b1); apply(2);
    expect_out(model, "R11 up after pulse, alt never shown");
    jog(5, "R7 five edges saturate to panic");
    expect_out(5'b11010, "R7 panic restores normal");
    jog(3, "R7 three edges panic at normal");

    stop_hi = 5'd27; stop_lo = 5'd25;
    jog(2, "R8 step to upper stop");
    jog(2, "R8 step past upper stop ignored");
    expect_out(5'd27, "R8 held at upper stop");
    jog(1, "R12 down 1");
    jog(1, "R12 second single edge is down again");
    expect_out(5'd25, "R12 counts do not accumulate");
    jog(1, "R9 step past lower stop ignored");
    expect_out(5'd25, "R9 held at lower stop");

    nrm_code = 5'd18; wait_clk(3);
    model = 5'd18;
    expect_out(5'd18, "R10 reload on normal change");
    stop_lo = 5'd0;
    jog(1, "R10 jog from reloaded value");

    jog_en = 1'b0; wait_clk(2);
    expect_out(5'd18, "R2 disabled follows normal");
    ctl_pin = 1'b1; wait_clk(4);
    expect_out(5'd20, "R2 disabled pin selects alternate");
    ctl_pin = 1'b0; wait_clk(4);
    jog_en = 1'b1; wait_clk(2);
    expect_out(5'd18, "R3 re-enable restarts at normal");

    wait_clk(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule